// File: doc/BRIEF.md
# Transceiver Fault and Interrupt Controller

This block collects the condition flags of a line-driver transceiver and turns them into three views: a live status word that mirrors each condition with one register of delay, a sticky interrupt word that remembers each event until software reads it, and a single active-low interrupt/overcurrent pin. The conditions are a fault flag for the communication-line driver, a fault flag for the auxiliary output driver, a supply low-voltage warning flag, a supply undervoltage flag and a wake-up event strobe. A fault here means overcurrent or overheating.

A mode select picks the pin behaviour. In pin mode, the output is a plain indicator that tracks the two driver faults, and nothing is latched. In serial mode, every source has its own sticky bit. The pin is the NOR of all sticky bits, and a read strobe for the interrupt register clears them. The low-voltage warning can be kept out of the interrupt path by an enable input. The undervoltage path cannot be masked.

The pin is produced by a four-state machine:

- `ST_PIN_QUIET` and `ST_PIN_FAULT` are the pin-mode states. The machine moves between them as the OR of the driver faults rises and falls.
- `ST_SER_QUIET` and `ST_SER_PEND` are the serial-mode states. The machine is in `ST_SER_PEND` whenever the next sticky word is non-zero, and returns to `ST_SER_QUIET` once a read leaves the word empty.
- A change of the mode select moves the machine into the matching pair of states on the next edge.

Top module: `tfic_ctrl`

## Requirements
- R1: While reset is asserted, and right after it, `status_o` is 0, `irq_word_o` is 0 and `irq_n_o` is 1.
- R2: On each clock edge `status_o` takes the current conditions, in both modes. The bit layout is: bit0 line-driver fault, bit1 auxiliary-driver fault, bit2 low-voltage warning, bit3 undervoltage. Each bit clears on the edge after its condition drops.
- R3: In pin mode, `irq_n_o` is 0 on the edge after either driver fault is high. It is 1 on the edge after both driver faults are low. `irq_word_o` is held at 0 in pin mode.
- R4: In serial mode, each driver fault sets only its own sticky bit: bit0 for the line driver and bit1 for the auxiliary driver.
- R5: In serial mode, a sticky bit stays set until an edge with `irq_rd_i` high. After that edge the bit is 0, unless its source is active.
- R6: When a source is active on the same edge as a read, its sticky bit stays set. Set takes priority over clear.
- R7: The low-voltage sticky bit (bit2) is set only when `lowv_i` and `warn_en_i` are both 1. With `warn_en_i` at 0, the warning changes neither `irq_word_o` nor `irq_n_o`.
- R8: In serial mode, `uv_i` always sets sticky bit3 and drives `irq_n_o` low, whatever the value of `warn_en_i`.
- R9: In serial mode, `wake_i` sets sticky bit4. In pin mode it has no effect on either `irq_word_o` or `irq_n_o`.
- R10: In serial mode, `irq_n_o` equals the NOR of all five sticky bits. This includes the auxiliary-driver bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| ser_mode_i | input | 1 | 1 = serial mode, 0 = pin mode |
| cq_flt_i | input | 1 | Line-driver overcurrent/overheat |
| aux_flt_i | input | 1 | Auxiliary-driver overcurrent/overheat |
| lowv_i | input | 1 | Supply below the warning level |
| uv_i | input | 1 | Supply below the lockout level |
| warn_en_i | input | 1 | Lets the low-voltage warning reach the interrupt path |
| wake_i | input | 1 | Wake-up event strobe |
| irq_rd_i | input | 1 | Interrupt register read strobe |
| status_o | output | 4 | Live status word |
| irq_word_o | output | 5 | Sticky interrupt word |
| irq_n_o | output | 1 | Interrupt/overcurrent pin, active low |

## Verification
The hardest case to reach is a read strobe that lands on the same edge as a source that is still active or becomes active again. The case is harder still when another sticky bit is already pending, because the clear and the set then meet in a single cycle. Directed steps force this case with a line-driver fault held across a read. The random phase then drives the read strobe about one cycle in four, with sparse, overlapping condition pulses and rare mode flips, so that clear-against-set collisions and mode changes with pending bits occur many times.

// File: rtl/tfic_pkg.sv
package tfic_pkg;
    localparam int NUM_SRC  = 5;
    localparam int NUM_STAT = 4;
    localparam int IDX_CQ   = 0;
    localparam int IDX_AUX  = 1;
    localparam int IDX_LOWV = 2;
    localparam int IDX_UV   = 3;
    localparam int IDX_WAKE = 4;

    typedef enum logic [1:0] {
        ST_PIN_QUIET = 2'd0,
        ST_PIN_FAULT = 2'd1,
        ST_SER_QUIET = 2'd2,
        ST_SER_PEND  = 2'd3
    } irq_state_e;
endpackage

// File: rtl/tfic_live_status.sv
module tfic_live_status #(
    parameter int W = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] cond_i,
    output logic [W-1:0] stat_o
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stat_o <= '0;
        else        stat_o <= cond_i;
    end
endmodule

// File: rtl/tfic_sticky_bit.sv
module tfic_sticky_bit (
    input  logic clk,
    input  logic rst_n,
    input  logic arm_i,
    input  logic set_i,
    input  logic clr_i,
    output logic nxt_o,
    output logic q_o
);
    always_comb begin
        if (!arm_i) nxt_o = 1'b0;
        else        nxt_o = set_i | (q_o & ~clr_i);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q_o <= 1'b0;
        else        q_o <= nxt_o;
    end

    p_set_wins_r6: assert property (@(posedge clk) disable iff (!rst_n)
        arm_i && set_i && clr_i |=> q_o)
        else $error("sticky bit lost a set during a read");
    p_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        arm_i && q_o && !clr_i |=> q_o)
        else $error("sticky bit dropped without a read");
    p_clear_r5: assert property (@(posedge clk) disable iff (!rst_n)
        arm_i && clr_i && !set_i |=> !q_o)
        else $error("sticky bit survived a read with no source");
    p_pin_idle_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !arm_i |=> !q_o)
        else $error("sticky bit set in pin mode");
endmodule

// File: rtl/tfic_irq_fsm.sv
module tfic_irq_fsm
    import tfic_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic ser_i,
    input  logic drv_fault_i,
    input  logic pend_nxt_i,
    output logic irq_n_o
);
    irq_state_e state_q, state_d;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_PIN_QUIET, ST_PIN_FAULT, ST_SER_QUIET, ST_SER_PEND: begin
                if (ser_i) state_d = pend_nxt_i  ? ST_SER_PEND  : ST_SER_QUIET;
                else       state_d = drv_fault_i ? ST_PIN_FAULT : ST_PIN_QUIET;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_PIN_QUIET;
        else        state_q <= state_d;
    end

    always_comb begin
        unique case (state_q)
            ST_PIN_QUIET: irq_n_o = 1'b1;
            ST_PIN_FAULT: irq_n_o = 1'b0;
            ST_SER_QUIET: irq_n_o = 1'b1;
            ST_SER_PEND:  irq_n_o = 1'b0;
        endcase
    end

    p_pin_track_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !ser_i |=> (irq_n_o == !$past(drv_fault_i)))
        else $error("pin-mode interrupt does not track driver faults");
endmodule

// File: rtl/tfic_ctrl.sv
module tfic_ctrl
    import tfic_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic                ser_mode_i,
    input  logic                cq_flt_i,
    input  logic                aux_flt_i,
    input  logic                lowv_i,
    input  logic                uv_i,
    input  logic                warn_en_i,
    input  logic                wake_i,
    input  logic                irq_rd_i,
    output logic [NUM_STAT-1:0] status_o,
    output logic [NUM_SRC-1:0]  irq_word_o,
    output logic                irq_n_o
);
    logic [NUM_STAT-1:0] cond;
    logic [NUM_SRC-1:0]  src_set;
    logic [NUM_SRC-1:0]  sticky_nxt;

    always_comb begin
        cond            = '0;
        cond[IDX_CQ]    = cq_flt_i;
        cond[IDX_AUX]   = aux_flt_i;
        cond[IDX_LOWV]  = lowv_i;
        cond[IDX_UV]    = uv_i;
        src_set           = '0;
        src_set[IDX_CQ]   = cq_flt_i;
        src_set[IDX_AUX]  = aux_flt_i;
        src_set[IDX_LOWV] = lowv_i & warn_en_i;
        src_set[IDX_UV]   = uv_i;
        src_set[IDX_WAKE] = wake_i;
    end

    tfic_live_status #(.W(NUM_STAT)) u_live (
        .clk    (clk),
        .rst_n  (rst_n),
        .cond_i (cond),
        .stat_o (status_o)
    );

    for (genvar g = 0; g < NUM_SRC; g++) begin : g_sticky
        tfic_sticky_bit u_bit (
            .clk   (clk),
            .rst_n (rst_n),
            .arm_i (ser_mode_i),
            .set_i (src_set[g]),
            .clr_i (irq_rd_i),
            .nxt_o (sticky_nxt[g]),
            .q_o   (irq_word_o[g])
        );
    end

    tfic_irq_fsm u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .ser_i       (ser_mode_i),
        .drv_fault_i (cq_flt_i | aux_flt_i),
        .pend_nxt_i  (|sticky_nxt),
        .irq_n_o     (irq_n_o)
    );

    p_uv_unmask_r8: assert property (@(posedge clk) disable iff (!rst_n)
        ser_mode_i && uv_i |=> irq_word_o[IDX_UV] && !irq_n_o)
        else $error("undervoltage did not raise an interrupt");
    p_warn_mask_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !warn_en_i && !irq_word_o[IDX_LOWV] |=> !irq_word_o[IDX_LOWV])
        else $error("masked warning set its sticky bit");
    p_nor_r10: assert property (@(posedge clk) disable iff (!rst_n)
        $past(ser_mode_i) |-> (irq_n_o == !(|irq_word_o)))
        else $error("serial pin differs from NOR of sticky word");
endmodule

// File: tb/tfic_ctrl_tb.sv
`timescale 1ns/1ps
module tfic_ctrl_tb_top;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic ser = 1'b0, cq = 1'b0, aux = 1'b0, lowv = 1'b0, uv = 1'b0;
    logic wen = 1'b0, wake = 1'b0, rd = 1'b0;
    logic [3:0] status;
    logic [4:0] irq_word;
    logic       irq_n;

    logic [3:0] e_stat = 4'd0;
    logic [4:0] e_irq  = 5'd0;
    logic       e_n    = 1'b1;
    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    tfic_ctrl dut_i (
        .clk(clk), .rst_n(rst_n), .ser_mode_i(ser), .cq_flt_i(cq),
        .aux_flt_i(aux), .lowv_i(lowv), .uv_i(uv), .warn_en_i(wen),
        .wake_i(wake), .irq_rd_i(rd), .status_o(status),
        .irq_word_o(irq_word), .irq_n_o(irq_n)
    );

    function automatic logic [4:0] f_sets();
        return {wake, uv, lowv & wen, aux, cq};
    endfunction

    function automatic logic [4:0] f_next_irq(logic [4:0] cur);
        if (!ser) return 5'd0;
        return f_sets() | (cur & ~{5{rd}});
    endfunction

    task automatic check(string tag, string what, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
        end
    endtask

    task automatic drive(logic s, logic c, logic a, logic l, logic u,
                         logic w, logic k, logic r);
        @(negedge clk);
        ser = s; cq = c; aux = a; lowv = l; uv = u; wen = w; wake = k; rd = r;
    endtask

    task automatic tick(string tag);
        @(posedge clk);
        if (!rst_n) begin
            e_stat = 4'd0; e_irq = 5'd0; e_n = 1'b1;
        end else begin
            e_stat = {uv, lowv, aux, cq};
            e_irq  = f_next_irq(e_irq);
            e_n    = ser ? !(|e_irq) : !(cq | aux);
        end
        #2;
        check("R2", "status", status, e_stat);
        check(tag, "irq_word", irq_word, e_irq);
        check(tag, "irq_n", irq_n, e_n);
    endtask

    task automatic step(string tag, logic s, logic c, logic a, logic l,
                        logic u, logic w, logic k, logic r);
        drive(s, c, a, l, u, w, k, r);
        tick(tag);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        int unused_seed;
        unused_seed = $urandom(32'h5eed_1234);
        // R1: reset holds outputs idle even with active conditions
        step("R1", 1, 1, 1, 1, 1, 1, 1, 0);
        step("R1", 1, 1, 1, 1, 1, 1, 1, 0);
        drive(1, 0, 0, 0, 0, 0, 0, 0);
        rst_n = 1'b1;
        tick("R1");
        // R3: pin mode tracks driver faults without latching
        step("R3", 0, 1, 0, 0, 0, 0, 0, 0);
        step("R3", 0, 0, 1, 0, 0, 0, 0, 0);
        step("R3", 0, 0, 0, 0, 0, 0, 0, 0);
        // R9: wake ignored in pin mode
        step("R9", 0, 0, 0, 0, 0, 0, 1, 0);
        step("R9", 0, 0, 0, 0, 0, 0, 0, 0);
        // R4/R10: auxiliary fault alone latches bit1 and drives the pin
        step("R4", 1, 0, 1, 0, 0, 0, 0, 0);
        step("R10", 1, 0, 0, 0, 0, 0, 0, 0);
        step("R5", 1, 0, 0, 0, 0, 0, 0, 0);
        step("R5", 1, 0, 0, 0, 0, 0, 0, 1);
        step("R5", 1, 0, 0, 0, 0, 0, 0, 0);
        // R6: fault held across a read keeps its bit
        step("R4", 1, 1, 0, 0, 0, 0, 0, 0);
        step("R6", 1, 1, 0, 0, 0, 0, 0, 1);
        step("R6", 1, 0, 0, 0, 0, 0, 0, 1);
        // R7: masked then enabled warning
        step("R7", 1, 0, 0, 1, 0, 0, 0, 0);
        step("R7", 1, 0, 0, 1, 0, 0, 0, 0);
        step("R7", 1, 0, 0, 1, 0, 1, 0, 0);
        step("R7", 1, 0, 0, 0, 0, 0, 0, 1);
        // R8: undervoltage unmaskable
        step("R8", 1, 0, 0, 0, 1, 0, 0, 0);
        step("R8", 1, 0, 0, 0, 0, 0, 0, 1);
        // R9: wake in serial mode
        step("R9", 1, 0, 0, 0, 0, 0, 1, 0);
        step("R9", 1, 0, 0, 0, 0, 0, 0, 0);
        step("R5", 1, 0, 0, 0, 0, 0, 0, 1);
        // random phase
        for (int i = 0; i < 3000; i++) begin
            logic s;
            s = ser;
            if (($urandom % 64) == 0) s = ~ser;
            step(s ? "R10" : "R3", s,
                 ($urandom % 6) == 0, ($urandom % 6) == 0,
                 ($urandom % 5) == 0, ($urandom % 9) == 0,
                 ($urandom % 2) == 0, ($urandom % 11) == 0,
                 ($urandom % 4) == 0);
        end
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule